// File: doc/BRIEF.md
# Flag-Controlled Arithmetic Logic Unit

This block is a purely combinational ALU for a 16-bit datapath. It has no opcode table. Six independent control bits build each function out of three stages. Each operand is first conditioned: it may be forced to zero, then inverted. A single core stage then either adds the two conditioned operands or ANDs them bitwise. A final stage may invert the result. With these bits the caller can form constants, pass-throughs, negation, increment, decrement, subtraction and the bitwise logic functions.

Three status flags come with the result. The zero flag is set when the whole result is zero. The negative flag is the result's sign bit. The overflow flag reports two's-complement overflow of the adder. The carry out of the top bit is not exposed. Multiply, divide and floating point are not provided.

Top module: `flag_alu`

## Requirements
- R1: When zx_i=1 the x operand is replaced by all zeros before any other processing.
- R2: When nx_i=1 the x operand left after the R1 stage is inverted bit by bit, so zx_i=1 with nx_i=1 gives 0xFFFF.
- R3: When zy_i=1 the y operand is replaced by all zeros before any other processing.
- R4: When ny_i=1 the y operand left after the R3 stage is inverted bit by bit.
- R5: When f_i=1 the core result is the sum of the conditioned operands modulo 2^16, and the carry out of bit 15 is dropped.
- R6: When f_i=0 the core result is the bitwise AND of the conditioned operands.
- R7: When no_i=1 the core result is inverted bit by bit before it reaches res_o.
- R8: zero_o is 1 exactly when all 16 bits of res_o are 0.
- R9: neg_o equals res_o bit 15.
- R10: ovf_o is the XOR of the carry into bit 15 and the carry out of bit 15 of the adder when f_i=1. It is independent of no_i and is 0 whenever f_i=0.
- R11: With all six control bits set to 1, res_o equals 0x0001 for any x_i and y_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 16 | First operand |
| y_i | input | 16 | Second operand |
| zx_i | input | 1 | Force x to zero |
| nx_i | input | 1 | Invert conditioned x |
| zy_i | input | 1 | Force y to zero |
| ny_i | input | 1 | Invert conditioned y |
| f_i | input | 1 | 1 selects add, 0 selects bitwise AND |
| no_i | input | 1 | Invert the core result |
| res_o | output | 16 | Result |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Result sign bit |
| ovf_o | output | 1 | Signed overflow of the add path |

## Verification
The bench builds the block at its default width of 16. At that width the sign-bit boundaries 0x7FFF and 0x8000 and the all-ones pattern can be hit directly as corner cases. Random operands are crossed with all 64 control combinations, so every ordering of the conditioning stages meets both the carry paths and the logic path. Directed vectors also cover both directions of signed overflow and the constant-one setting.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int unsigned DATA_W = 16;

  typedef struct packed {
    logic zx;
    logic nx;
    logic zy;
    logic ny;
    logic f;
    logic no;
  } alu_ctrl_t;
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] d_i,
  input  logic             zero_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] d_o
);
  // zero first, then invert
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign d_o[b] = (d_i[b] & ~zero_i) ^ inv_i;
  end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             add_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] res_o,
  output logic             ovf_o
);
  localparam int unsigned LOW_W = WIDTH - 1;

  logic [LOW_W:0]   low_sum;   // carry into MSB at top bit
  logic             c_into_msb;
  logic             c_out_msb;
  logic             msb_sum;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] conj;
  logic [WIDTH-1:0] sel;

  assign low_sum    = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_i[LOW_W-1:0]};
  assign c_into_msb = low_sum[LOW_W];
  assign msb_sum    = a_i[WIDTH-1] ^ b_i[WIDTH-1] ^ c_into_msb;
  assign c_out_msb  = (a_i[WIDTH-1] & b_i[WIDTH-1]) |
                      (c_into_msb & (a_i[WIDTH-1] ^ b_i[WIDTH-1]));
  assign sum        = {msb_sum, low_sum[LOW_W-1:0]};
  assign conj       = a_i & b_i;
  assign sel        = add_i ? sum : conj;
  assign res_o      = sel ^ {WIDTH{inv_i}};
  assign ovf_o      = add_i & (c_into_msb ^ c_out_msb);
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] res_i,
  output logic             zero_o,
  output logic             neg_o
);
  localparam int unsigned HALF_W = WIDTH / 2;

  logic any_lo;
  logic any_hi;

  if ((WIDTH % 2) == 0) begin : g_even
    assign any_lo = |res_i[HALF_W-1:0];
    assign any_hi = |res_i[WIDTH-1:HALF_W];
  end else begin : g_odd
    assign any_lo = |res_i[HALF_W-1:0];
    assign any_hi = |res_i[WIDTH-1:HALF_W];
  end

  assign zero_o = ~(any_lo | any_hi);
  assign neg_o  = res_i[WIDTH-1];
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             zx_i,
  input  logic             nx_i,
  input  logic             zy_i,
  input  logic             ny_i,
  input  logic             f_i,
  input  logic             no_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             neg_o,
  output logic             ovf_o
);
  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] x_proc;
  logic [WIDTH-1:0] y_proc;

  assign ctrl = '{zx: zx_i, nx: nx_i, zy: zy_i, ny: ny_i, f: f_i, no: no_i};

  alu_operand_prep #(.WIDTH(WIDTH)) u_prep_x (
    .d_i(x_i), .zero_i(ctrl.zx), .inv_i(ctrl.nx), .d_o(x_proc)
  );

  alu_operand_prep #(.WIDTH(WIDTH)) u_prep_y (
    .d_i(y_i), .zero_i(ctrl.zy), .inv_i(ctrl.ny), .d_o(y_proc)
  );

  alu_core #(.WIDTH(WIDTH)) u_core (
    .a_i(x_proc), .b_i(y_proc), .add_i(ctrl.f), .inv_i(ctrl.no),
    .res_o(res_o), .ovf_o(ovf_o)
  );

  alu_flags #(.WIDTH(WIDTH)) u_flags (
    .res_i(res_o), .zero_o(zero_o), .neg_o(neg_o)
  );
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] x_proc,
  input logic [WIDTH-1:0] y_proc,
  input logic             zx_i,
  input logic             nx_i,
  input logic             zy_i,
  input logic             ny_i,
  input logic             f_i,
  input logic             no_i,
  input logic [WIDTH-1:0] res_o,
  input logic             zero_o,
  input logic             neg_o,
  input logic             ovf_o
);
  logic known;
  assign known = !$isunknown({x_proc, y_proc, zx_i, nx_i, zy_i, ny_i, f_i, no_i,
                              res_o, zero_o, neg_o, ovf_o});

  always_comb begin
    if (known) begin
      a_r8_zero_flag: assert (zero_o == (res_o == '0));
      a_r9_neg_flag: assert (neg_o == res_o[WIDTH-1]);
      if (!f_i) begin
        a_r10_no_ovf_on_and: assert (!ovf_o);
      end
      if (f_i && !no_i) begin
        a_r10_sign_rule: assert (ovf_o == ((x_proc[WIDTH-1] == y_proc[WIDTH-1]) &&
                                           (res_o[WIDTH-1] != x_proc[WIDTH-1])));
      end
      if (zx_i && nx_i && zy_i && ny_i && f_i && no_i) begin
        a_r11_const_one: assert (res_o == WIDTH'(1));
      end
      if (zx_i && !nx_i) begin
        a_r1_x_zeroed: assert (x_proc == '0);
      end
      if (zy_i && ny_i) begin
        a_r4_y_ones: assert (y_proc == '1);
      end
    end
  end
endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .x_proc(x_proc), .y_proc(y_proc),
  .zx_i(zx_i), .nx_i(nx_i), .zy_i(zy_i), .ny_i(ny_i), .f_i(f_i), .no_i(no_i),
  .res_o(res_o), .zero_o(zero_o), .neg_o(neg_o), .ovf_o(ovf_o)
);

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
  localparam int unsigned W = 16;
  localparam int unsigned N_RAND = 3000;
  localparam int unsigned WDOG = 50000;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] x_i = '0, y_i = '0;
  logic         zx_i = 1'b0, nx_i = 1'b0, zy_i = 1'b0, ny_i = 1'b0, f_i = 1'b0, no_i = 1'b0;
  logic [W-1:0] res_o;
  logic         zero_o, neg_o, ovf_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flag_alu dut (
    .x_i(x_i), .y_i(y_i), .zx_i(zx_i), .nx_i(nx_i), .zy_i(zy_i), .ny_i(ny_i),
    .f_i(f_i), .no_i(no_i), .res_o(res_o), .zero_o(zero_o), .neg_o(neg_o), .ovf_o(ovf_o)
  );

  // expected {ovf, neg, zero, res}
  function automatic logic [W+2:0] model(logic [W-1:0] x, logic [W-1:0] y, logic [5:0] c);
    logic [W-1:0] a, b, r;
    logic         ov;
    a = c[5] ? '0 : x;              // R1
    if (c[4]) a = ~a;               // R2
    b = c[3] ? '0 : y;              // R3
    if (c[2]) b = ~b;               // R4
    if (c[1]) begin
      r  = a + b;                   // R5
      ov = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
    end else begin
      r  = a & b;                   // R6
      ov = 1'b0;
    end
    if (c[0]) r = ~r;               // R7
    return {ov, r[W-1], (r == '0), r};
  endfunction

  task automatic apply(string req, logic [W-1:0] x, logic [W-1:0] y, logic [5:0] c);
    logic [W+2:0] exp_v, act;
    @(negedge clk);
    x_i = x; y_i = y;
    {zx_i, nx_i, zy_i, ny_i, f_i, no_i} = c;
    @(posedge clk);
    #1;
    exp_v = model(x, y, c);
    act   = {ovf_o, neg_o, zero_o, res_o};
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s x=%h y=%h ctrl=%b actual=%h expected=%h", req, x, y, c, act, exp_v);
    end
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset-state style check: idle inputs give zero result and zero flag (R8)
    apply("R8", 16'h0000, 16'h0000, 6'b000000);
    apply("R11", 16'h1234, 16'hBEEF, 6'b111111);
    apply("R11", 16'hFFFF, 16'h0000, 6'b111111);
    apply("R1", 16'hABCD, 16'h0F0F, 6'b100010);
    apply("R2", 16'h1357, 16'h5A5A, 6'b110000);
    apply("R3", 16'hAAAA, 16'h9999, 6'b001010);
    apply("R4", 16'hC3C3, 16'h7777, 6'b001100);
    apply("R5", 16'hFFFF, 16'h0001, 6'b000010);
    apply("R10", 16'h7FFF, 16'h0001, 6'b000010);
    apply("R10", 16'h8000, 16'h8000, 6'b000010);
    apply("R10", 16'h7FFF, 16'h0001, 6'b000011);
    apply("R10", 16'hFFFF, 16'hFFFF, 6'b000000);
    apply("R6", 16'hF0F0, 16'h3C3C, 6'b000000);
    apply("R7", 16'hF0F0, 16'h3C3C, 6'b000001);
    apply("R9", 16'h8000, 16'hFFFF, 6'b000000);
    apply("R8", 16'h0001, 16'hFFFF, 6'b000010);
    for (int k = 0; k < N_RAND; k++) begin
      logic [W-1:0] rx, ry;
      rx = W'($urandom);
      ry = W'($urandom);
      if (k % 7 == 0) rx = 16'h7FFF;
      if (k % 11 == 0) ry = 16'h8000;
      apply("R5_R6_R7", rx, ry, 6'(k % 64));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < WDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule